// File: doc/BRIEF.md
# Multiplexed-Bus Microcontroller Slave Bridge

This block gives an external microcontroller access to a small byte-wide register space inside a synchronous design. The microcontroller is always the bus master and the bridge only answers. The bus has eight dedicated high address pins and eight shared pins that carry the low address byte first and the data byte later. A latch-enable strobe marks when the address is on the pins, and separate active-low strobes mark a write or a read.

The low address byte stays on the shared pins for only about 5 ns after latch-enable falls. That is shorter than one period of the system clock, so the full 16-bit address is stored by flops clocked on the falling edge of latch-enable itself. The write and read strobes pass through two-flop synchronizers into the system clock domain. A falling edge on a synchronized strobe copies the stored address into the system domain and issues a single-cycle request on the internal register port. By that time the stored address has been stable for several cycles.

On a write, the data byte is taken from the shared pins while the strobe is still low. On a read, the bridge captures the register file's reply and drives it onto the shared pins. It drives the pins only while the synchronized read strobe is low.

Top module: `mcu_bus_bridge`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `bus_ad_oe`, `reg_we` and `reg_re` are all 0.
- R2: `reg_addr` equals `{bus_addr_hi, bus_ad_in}` as they stood at the last falling edge of `bus_ale`. Changes on those pins after that edge have no effect on the address of the following request.
- R3: Each low period of `bus_wr_n` produces exactly one `reg_we` pulse, one clock cycle wide.
- R4: `reg_we` is high in the clock cycle that follows the third rising clock edge after `bus_wr_n` falls. In that cycle `reg_wdata` equals the byte held on `bus_ad_in` while the write strobe is low.
- R5: Each low period of `bus_rd_n` produces exactly one `reg_re` pulse, one cycle wide. The pulse comes after the third rising clock edge following the strobe's fall.
- R6: The register file answers one cycle after `reg_re`. From the second cycle after `reg_re` until the driver is released, `bus_ad_out` carries that reply.
- R7: `bus_ad_oe` is 1 only when the synchronized read strobe is low. It stays 0 while the bus is idle. After `bus_rd_n` rises it is still 1 two edges later and is 0 from the third rising edge on.
- R8: `reg_we` and `reg_re` are never high together. If both strobes fall in the same cycle, only the write is issued.
- R9: Asserting `rst` during a read releases `bus_ad_oe` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| bus_ale | input | 1 | Address latch enable; the address is stored on its falling edge |
| bus_wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_rd_n | input | 1 | Active-low read strobe, asynchronous |
| bus_addr_hi | input | 8 | Dedicated high address pins |
| bus_ad_in | input | 8 | Shared address/data pins, input side |
| bus_ad_out | output | 8 | Shared pins, read data to drive |
| bus_ad_oe | output | 1 | Output enable for the shared pins |
| reg_addr | output | 16 | Register port address |
| reg_we | output | 1 | Single-cycle write request |
| reg_re | output | 1 | Single-cycle read request |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data from the register file, one cycle after `reg_re` |

## Verification
Any fault in a synchronizer or edge-detector flop appears at the register port as a missing, doubled or shifted `reg_we`/`reg_re` pulse, within three to four cycles of the strobe edge. A fault in the latch-enable domain appears as a wrong `reg_addr` on the very next request. This includes capture after the hold window, where the pins already carry changed values. A fault in the driver state appears as `bus_ad_oe` staying high after release, or rising when the bus is idle, within three cycles of the read strobe rising. The bench sweeps many addresses and data patterns. It also covers simultaneous strobes and a reset in the middle of a read.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Default bus geometry: dedicated high pins plus shared low/data pins
    localparam int HI_W_DEF    = 8;
    localparam int AD_W_DEF    = 8;
    localparam int SYNC_DEF    = 2;

    // Kind of request produced by one synchronized strobe edge
    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_READ  = 2'd2
    } req_kind_e;

    // Single-cycle request flags carried to the register port
    typedef struct packed {
        logic we;
        logic re;
    } req_pulse_t;

    // Write wins when both strobes fall in the same cycle (R8)
    function automatic req_kind_e pick_kind(input logic wr_fall, input logic rd_fall);
        if (wr_fall)      return REQ_WRITE;
        else if (rd_fall) return REQ_READ;
        else              return REQ_IDLE;
    endfunction

endpackage

// File: rtl/bridge_addr_latch.sv
// Address store clocked by the falling edge of the latch-enable strobe.
// The low byte is only valid very briefly after that edge, so no system-clock
// sampling is used here.
module bridge_addr_latch #(
    parameter int HI_W = 8,
    parameter int AD_W = 8,
    localparam int ADDR_W = HI_W + AD_W
) (
    input  logic              ale,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [AD_W-1:0]   ad_in,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] held_q;

    always_ff @(negedge ale) begin
        held_q <= {addr_hi, ad_in};
    end

    assign addr_o = held_q;

endmodule

// File: rtl/bridge_strobe_sync.sv
// Multi-stage synchronizer for an active-low asynchronous strobe, with a
// falling-edge detector on the synchronized level.
module bridge_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_n};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/bridge_req_gen.sv
// Turns synchronized strobe edges into single-cycle register-port requests.
// The address is copied from the latch-enable domain only on an edge, when it
// has long been stable.
module bridge_req_gen
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fall,
    input  logic              rd_fall,
    input  logic [ADDR_W-1:0] latched_addr,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output req_pulse_t        req_pulse
);

    req_kind_e         kind;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    req_pulse_t        pulse_q;

    always_comb begin
        kind = pick_kind(wr_fall, rd_fall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q.we <= (kind == REQ_WRITE);
            pulse_q.re <= (kind == REQ_READ);
            if (kind != REQ_IDLE) begin
                addr_q <= latched_addr;
            end
            if (kind == REQ_WRITE) begin
                wdata_q <= ad_in;
            end
        end
    end

    assign req_addr  = addr_q;
    assign req_wdata = wdata_q;
    assign req_pulse = pulse_q;

endmodule

// File: rtl/bridge_read_drive.sv
// Captures the register file reply and controls the shared-pin driver.
module bridge_read_drive #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_level,
    input  logic              req_re,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    logic              re_d_q;
    logic [DATA_W-1:0] hold_q;
    logic              oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            re_d_q <= 1'b0;
            hold_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            re_d_q <= req_re;
            oe_q   <= ~rd_level;
            if (re_d_q) begin
                hold_q <= reg_rdata;
            end
        end
    end

    assign ad_out = hold_q;
    assign ad_oe  = oe_q;

endmodule

// File: rtl/mcu_bus_bridge.sv
module mcu_bus_bridge
    import bridge_pkg::*;
#(
    parameter int HI_W        = HI_W_DEF,
    parameter int AD_W        = AD_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    localparam int ADDR_W     = HI_W + AD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ale,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [HI_W-1:0]   bus_addr_hi,
    input  logic [AD_W-1:0]   bus_ad_in,
    output logic [AD_W-1:0]   bus_ad_out,
    output logic              bus_ad_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic              reg_re,
    output logic [AD_W-1:0]   reg_wdata,
    input  logic [AD_W-1:0]   reg_rdata
);

    logic [ADDR_W-1:0] latched_addr;
    logic              wr_level, wr_fall;
    logic              rd_level, rd_fall;
    req_pulse_t        pulse;

    bridge_addr_latch #(.HI_W(HI_W), .AD_W(AD_W)) u_latch (
        .ale     (bus_ale),
        .addr_hi (bus_addr_hi),
        .ad_in   (bus_ad_in),
        .addr_o  (latched_addr)
    );

    bridge_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (bus_wr_n),
        .level_o  (wr_level),
        .fall_o   (wr_fall)
    );

    bridge_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (bus_rd_n),
        .level_o  (rd_level),
        .fall_o   (rd_fall)
    );

    bridge_req_gen #(.ADDR_W(ADDR_W), .DATA_W(AD_W)) u_req (
        .clk          (clk),
        .rst          (rst),
        .wr_fall      (wr_fall),
        .rd_fall      (rd_fall),
        .latched_addr (latched_addr),
        .ad_in        (bus_ad_in),
        .req_addr     (reg_addr),
        .req_wdata    (reg_wdata),
        .req_pulse    (pulse)
    );

    bridge_read_drive #(.DATA_W(AD_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .rd_level  (rd_level),
        .req_re    (pulse.re),
        .reg_rdata (reg_rdata),
        .ad_out    (bus_ad_out),
        .ad_oe     (bus_ad_oe)
    );

    assign reg_we = pulse.we;
    assign reg_re = pulse.re;

    // The write-strobe level is only needed for edge detection.
    logic unused_wr_level;
    assign unused_wr_level = wr_level;

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker (
    input logic clk,
    input logic rst,
    input logic bus_rd_n,
    input logic bus_ad_oe,
    input logic reg_we,
    input logic reg_re
);

    // Counts consecutive samples of the read strobe high, saturating at 3
    logic [1:0] rd_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_high_cnt <= 2'd0;
        end else if (!bus_rd_n) begin
            rd_high_cnt <= 2'd0;
        end else if (rd_high_cnt != 2'd3) begin
            rd_high_cnt <= rd_high_cnt + 2'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!bus_ad_oe && !reg_we && !reg_re));

    assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_re_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    assert_re_has_driver_R7: assert property (@(posedge clk) disable iff (rst)
        reg_re |-> bus_ad_oe);

    assert_oe_released_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_high_cnt == 2'd3) |-> !bus_ad_oe);

    assert_no_dual_req_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

endmodule

bind mcu_bus_bridge bridge_checker u_bridge_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_rd_n  (bus_rd_n),
    .bus_ad_oe (bus_ad_oe),
    .reg_we    (reg_we),
    .reg_re    (reg_re)
);

// File: tb/tb_mcu_bus_bridge.sv
module tb_mcu_bus_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_ale;
    logic        bus_wr_n;
    logic        bus_rd_n;
    logic [7:0]  bus_addr_hi;
    logic [7:0]  bus_ad_in;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] reg_addr;
    logic        reg_we;
    logic        reg_re;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Write/read pulse observation (sampled on the falling clock edge)
    int          we_cnt = 0, re_cnt = 0;
    int          we_cyc = 0, re_cyc = 0;
    logic [15:0] we_addr, re_addr;
    logic [7:0]  we_data;

    always #4 clk = ~clk;

    mcu_bus_bridge dut (
        .clk         (clk),
        .rst         (rst),
        .bus_ale     (bus_ale),
        .bus_wr_n    (bus_wr_n),
        .bus_rd_n    (bus_rd_n),
        .bus_addr_hi (bus_addr_hi),
        .bus_ad_in   (bus_ad_in),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    function automatic logic [7:0] model_rd(input logic [15:0] a);
        return (a[7:0] * 8'd3 + a[15:8]) ^ 8'hA5;
    endfunction

    // Register file model: one cycle of read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (reg_re) reg_rdata <= model_rd(reg_addr);
    end

    always @(negedge clk) begin
        if (reg_we) begin
            we_cnt  = we_cnt + 1;
            we_cyc  = cyc;
            we_addr = reg_addr;
            we_data = reg_wdata;
        end
        if (reg_re) begin
            re_cnt  = re_cnt + 1;
            re_cyc  = cyc;
            re_addr = reg_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic put_addr(input logic [15:0] a);
        @(negedge clk);
        bus_addr_hi = a[15:8];
        bus_ad_in   = a[7:0];
        bus_ale     = 1'b1;
        @(negedge clk);
        bus_ale     = 1'b0;
        #1;
        // hold window over: pins move on
        bus_addr_hi = ~a[15:8];
        bus_ad_in   = ~a[7:0];
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        int we0, fall_cyc;
        we0 = we_cnt;
        put_addr(a);
        bus_ad_in = d;
        @(negedge clk);
        bus_wr_n = 1'b0;
        fall_cyc = cyc;
        repeat (5) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(we_cnt == we0 + 1, "R3 one write pulse", we_cnt - we0, 1);
        chk(we_addr == a, "R2 write address", we_addr, a);
        chk(we_data == d, "R4 write data", we_data, d);
        chk(we_cyc == fall_cyc + 3, "R4 write timing", we_cyc - fall_cyc, 3);
    endtask

    task automatic bus_read(input logic [15:0] a);
        int re0, fall_cyc;
        re0 = re_cnt;
        put_addr(a);
        @(negedge clk);
        chk(bus_ad_oe == 1'b0, "R7 idle driver off", bus_ad_oe, 0);
        bus_rd_n = 1'b0;
        fall_cyc = cyc;
        repeat (7) @(negedge clk);
        chk(re_cnt == re0 + 1, "R5 one read pulse", re_cnt - re0, 1);
        chk(re_cyc == fall_cyc + 3, "R5 read timing", re_cyc - fall_cyc, 3);
        chk(re_addr == a, "R2 read address", re_addr, a);
        chk(bus_ad_oe == 1'b1, "R7 driver on", bus_ad_oe, 1);
        chk(bus_ad_out == model_rd(a), "R6 read data", bus_ad_out, model_rd(a));
        bus_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_ad_oe == 1'b1, "R7 held through sync", bus_ad_oe, 1);
        @(negedge clk);
        chk(bus_ad_oe == 1'b0, "R7 released", bus_ad_oe, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        rst         = 1'b1;
        bus_ale     = 1'b0;
        bus_wr_n    = 1'b1;
        bus_rd_n    = 1'b1;
        bus_addr_hi = 8'h00;
        bus_ad_in   = 8'h00;
        repeat (4) @(negedge clk);
        chk(bus_ad_oe == 1'b0, "R1 reset driver", bus_ad_oe, 0);
        chk(reg_we == 1'b0, "R1 reset we", reg_we, 0);
        chk(reg_re == 1'b0, "R1 reset re", reg_re, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            bus_write({8'(i * 29 + 7), 8'(i * 53 + 1)}, 8'(i * 71 + 9));
        end
        bus_write(16'h0000, 8'h00);
        bus_write(16'hFFFF, 8'hFF);

        for (int i = 0; i < 40; i++) begin
            bus_read({8'(i * 37 + 3), 8'(i * 19 + 250)});
        end
        bus_read(16'h0000);
        bus_read(16'hFFFF);

        // R8: both strobes fall together, only the write goes out
        begin
            int we0, re0;
            we0 = we_cnt;
            re0 = re_cnt;
            put_addr(16'h1234);
            bus_ad_in = 8'h5C;
            @(negedge clk);
            bus_wr_n = 1'b0;
            bus_rd_n = 1'b0;
            repeat (6) @(negedge clk);
            chk(we_cnt == we0 + 1, "R8 write issued", we_cnt - we0, 1);
            chk(re_cnt == re0, "R8 read suppressed", re_cnt - re0, 0);
            chk(we_addr == 16'h1234, "R8 write address", we_addr, 16'h1234);
            bus_wr_n = 1'b1;
            bus_rd_n = 1'b1;
            repeat (5) @(negedge clk);
            chk(bus_ad_oe == 1'b0, "R8 driver released", bus_ad_oe, 0);
        end

        // R9: reset in the middle of a read
        put_addr(16'hBEEF);
        @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(bus_ad_oe == 1'b1, "R9 driver on before reset", bus_ad_oe, 1);
        rst      = 1'b1;
        bus_rd_n = 1'b1;
        @(negedge clk);
        chk(bus_ad_oe == 1'b0, "R9 reset releases driver", bus_ad_oe, 0);
        chk(reg_re == 1'b0, "R1 reset re mid-run", reg_re, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        bus_write(16'hA55A, 8'h3C);
        bus_read(16'h5AA5);

        finish_run();
    end

endmodule